// File: doc/BRIEF.md
# Dual-Edge PDM Microphone Receiver

This block takes a single pulse-density-modulated data line that carries two microphone channels. One channel is valid around the rising edge of the PDM bit clock and the other around the falling edge. Each captured bit is delivered as a one-bit beat on its own output stream in the system clock domain. A configuration input swaps which clock edge feeds which output channel. Each channel has its own enable.

The PDM bit clock pin can work in two ways. As a slave, it is an input of any phase relative to the system clock. As a master, the block drives it from a divider on the 24.576 MHz system clock. The divider produces 3.072 MHz (divide by 8) or 6.144 MHz (divide by 4) with an exact 50% duty cycle. A run input gates the master clock. When the clock is gated, the pin sits low. A gate request that arrives during a high phase takes effect only after that phase has completed, so no shortened pulse appears.

In both modes, the clock and data lines pass through the same two-flop synchronizer. Edges are detected on the synchronized clock, and the synchronized data is captured one system cycle after each detected edge.

The output streams carry valid and data only, with no ready input. A PDM source cannot be paused, so there is no back-pressure. The consumer must take every beat in the cycle it is presented, and a beat that is not taken is lost.

Top module: `pdm_ddr_rx`

## Requirements
- R1: While reset is held and right after it is released, `ch0_valid`, `ch1_valid`, `pdm_clk_out` and `pdm_clk_oe` are all 0.
- R2: In slave mode (`cfg_clk_master`=0), `pdm_clk_oe` is 0. With `cfg_edge_swap`=0, bits present at rising edges of `pdm_clk_in` appear in order on channel 0, and bits present at falling edges appear in order on channel 1.
- R3: With `cfg_edge_swap`=1, the assignment is reversed: rising-edge bits go to channel 1 and falling-edge bits go to channel 0.
- R4: The slave clock needs no phase or integer-ratio relation to `clk`. Every edge of a slave clock whose half period is at least three system cycles yields exactly one correct beat.
- R5: In master mode with `cfg_clk_run`=1 and `cfg_rate_fast`=0, `pdm_clk_oe` is 1 and `pdm_clk_out` has high and low phases of exactly 4 system cycles each.
- R6: With `cfg_rate_fast`=1, the master high and low phases are exactly 2 system cycles each.
- R7: In master mode, the data line is captured on both edges of the driven clock. The edge-to-channel assignment is the same as in R2 and R3, at both rates.
- R8: In master mode with `cfg_clk_run`=0, `pdm_clk_out` stays low, `pdm_clk_oe` stays 1 and no valid strobe is produced.
- R9: If `cfg_clk_run` falls during a high phase, that phase still lasts its full length before the clock stops low.
- R10: While `cfg_ch_en[i]` is 0, channel i gives no valid strobes. The other channel is unaffected (bit 0 controls channel 0 and bit 1 controls channel 1).
- R11: Each captured bit raises its channel's valid for exactly one system cycle, so the number of beats equals the number of edges assigned to that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 24.576 MHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_clk_master | input | 1 | 1: block drives the PDM clock; 0: PDM clock is an input |
| cfg_edge_swap | input | 1 | 0: rising edge to channel 0; 1: rising edge to channel 1 |
| cfg_clk_run | input | 1 | Master clock gate, 1 lets the clock run |
| cfg_rate_fast | input | 1 | 0: 3.072 MHz master clock; 1: 6.144 MHz |
| cfg_ch_en | input | 2 | Per-channel enable, bit i for channel i |
| pdm_clk_in | input | 1 | PDM clock from the pin in slave mode |
| pdm_clk_out | output | 1 | PDM clock driven in master mode |
| pdm_clk_oe | output | 1 | Output enable for the PDM clock pin |
| pdm_data | input | 1 | Shared PDM data line |
| ch0_valid | output | 1 | Channel 0 beat strobe |
| ch0_data | output | 1 | Channel 0 bit |
| ch1_valid | output | 1 | Channel 1 beat strobe |
| ch1_data | output | 1 | Channel 1 bit |

## Verification
A divider counter that has drifted shows up within one PDM period as a high or low phase of the wrong length on `pdm_clk_out`. A gate that releases early shows up as a shortened final pulse.

A stale edge-history flop or a wrong channel select shows up at the first captured bit. The symptom is a bit stream on the wrong channel, a duplicated beat or a missing beat. The bench drives two different patterns on opposite edges, so any swap or lost beat changes the received words.

An enable or gate that leaks shows up as strobes during a window in which both must be silent.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;

  typedef struct packed {
    logic valid;
    logic data;
  } pdm_beat_t;

  localparam int unsigned PDM_CHANNELS = 2;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pdm_sync.sv
module pdm_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= async_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen
  import pdm_rx_pkg::*;
#(
  parameter int unsigned HALF_SLOW = 4,
  parameter int unsigned HALF_FAST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic rate_fast,
  output logic clk_q
);

  localparam int unsigned HMAX = max_u(HALF_SLOW, HALF_FAST);
  localparam int unsigned CW   = $clog2(HMAX) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half_m1;

  assign half_m1 = rate_fast ? CW'(HALF_FAST - 1) : CW'(HALF_SLOW - 1);

  // Idle only when low: a high phase always completes before stopping.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!run_en && !clk_q) begin
      cnt_q <= '0;
    end else if (cnt_q >= half_m1) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Checker state: measure each high phase independently of the divider.
  logic          q_d;
  logic [CW-1:0] hi_len;
  logic          rate_ref;
  logic          rate_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_d      <= 1'b0;
      hi_len   <= '0;
      rate_ref <= 1'b0;
      rate_ok  <= 1'b0;
    end else begin
      q_d <= clk_q;
      if (clk_q && !q_d) begin
        hi_len   <= CW'(1);
        rate_ref <= rate_fast;
        rate_ok  <= 1'b1;
      end else if (clk_q) begin
        hi_len <= hi_len + 1'b1;
        if (rate_fast != rate_ref) rate_ok <= 1'b0;
      end
    end
  end

  // R5, R6 and R9: every high phase has the full half-period length.
  assert_half_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_q && q_d && rate_ok) |->
      (hi_len == (rate_ref ? CW'(HALF_FAST) : CW'(HALF_SLOW))));

  // R8: once gated and low, the clock stays low.
  assert_gated_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clk_q) |=> !clk_q);

endmodule

// File: rtl/pdm_edge_split.sv
module pdm_edge_split
  import pdm_rx_pkg::*;
#(
  parameter int unsigned NCH = PDM_CHANNELS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_s,
  input  logic                 data_s,
  input  logic                 swap,
  input  logic [NCH-1:0]       ch_en,
  output pdm_beat_t [NCH-1:0]  beat_o
);

  logic clk_prev;
  logic rise_evt;
  logic fall_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b0;
    else        clk_prev <= clk_s;
  end

  assign rise_evt = clk_s & ~clk_prev;
  assign fall_evt = ~clk_s & clk_prev;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic on_rise;
    logic evt;
    pdm_beat_t beat_q;

    assign on_rise = (1'(i == 0)) ^ swap;
    assign evt     = on_rise ? rise_evt : fall_evt;

    // Capture one cycle after the edge is detected.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        beat_q <= '0;
      end else begin
        beat_q.valid <= evt & ch_en[i];
        if (evt) beat_q.data <= data_s;
      end
    end

    assign beat_o[i] = beat_q;

    // R11: a beat strobe lasts exactly one cycle.
    assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      beat_q.valid |=> !beat_q.valid);

    // R10: a disabled channel stays silent.
    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |=> !beat_q.valid);
  end

endmodule

// File: rtl/pdm_ddr_rx.sv
module pdm_ddr_rx
  import pdm_rx_pkg::*;
#(
  parameter int unsigned HALF_SLOW   = 4,
  parameter int unsigned HALF_FAST   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_clk_master,
  input  logic       cfg_edge_swap,
  input  logic       cfg_clk_run,
  input  logic       cfg_rate_fast,
  input  logic [1:0] cfg_ch_en,
  input  logic       pdm_clk_in,
  output logic       pdm_clk_out,
  output logic       pdm_clk_oe,
  input  logic       pdm_data,
  output logic       ch0_valid,
  output logic       ch0_data,
  output logic       ch1_valid,
  output logic       ch1_data
);

  logic gen_q;
  logic edge_src;
  logic [1:0] sync_out;
  pdm_beat_t [PDM_CHANNELS-1:0] beats;

  pdm_clk_gen #(
    .HALF_SLOW (HALF_SLOW),
    .HALF_FAST (HALF_FAST)
  ) u_clk_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (cfg_clk_master & cfg_clk_run),
    .rate_fast (cfg_rate_fast),
    .clk_q     (gen_q)
  );

  // The driven clock takes the same synchronizer path as the data line.
  assign edge_src = cfg_clk_master ? gen_q : pdm_clk_in;

  pdm_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({pdm_data, edge_src}),
    .sync_o  (sync_out)
  );

  pdm_edge_split #(
    .NCH (PDM_CHANNELS)
  ) u_split (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_s  (sync_out[0]),
    .data_s (sync_out[1]),
    .swap   (cfg_edge_swap),
    .ch_en  (cfg_ch_en),
    .beat_o (beats)
  );

  assign pdm_clk_out = cfg_clk_master & gen_q;
  assign pdm_clk_oe  = cfg_clk_master;
  assign ch0_valid   = beats[0].valid;
  assign ch0_data    = beats[0].data;
  assign ch1_valid   = beats[1].valid;
  assign ch1_data    = beats[1].data;

endmodule

// File: tb/test_pdm_ddr_rx.sv
`timescale 1ns/1ps
module test_pdm_ddr_rx;

  localparam real CLK_PERIOD = 40.0;
  localparam real SLV_STEP   = 87.3;
  localparam int  NB         = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_clk_master = 1'b0, cfg_edge_swap = 1'b0, cfg_clk_run = 1'b0;
  logic cfg_rate_fast = 1'b0;
  logic [1:0] cfg_ch_en = 2'b11;
  logic pdm_clk_in = 1'b0, pdm_data = 1'b0;
  logic pdm_clk_out, pdm_clk_oe, ch0_valid, ch0_data, ch1_valid, ch1_data;

  int tests = 0, fails = 0;
  int n0 = 0, n1 = 0, viol = 0;
  logic [63:0] got0 = '0, got1 = '0;
  logic pv0 = 1'b0, pv1 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdm_ddr_rx i_pdm_ddr_rx (
    .clk(clk), .rst_n(rst_n), .cfg_clk_master(cfg_clk_master),
    .cfg_edge_swap(cfg_edge_swap), .cfg_clk_run(cfg_clk_run),
    .cfg_rate_fast(cfg_rate_fast), .cfg_ch_en(cfg_ch_en),
    .pdm_clk_in(pdm_clk_in), .pdm_clk_out(pdm_clk_out), .pdm_clk_oe(pdm_clk_oe),
    .pdm_data(pdm_data), .ch0_valid(ch0_valid), .ch0_data(ch0_data),
    .ch1_valid(ch1_valid), .ch1_data(ch1_data)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (ch0_valid) begin
        if (n0 < 64) got0[n0] = ch0_data;
        n0++;
      end
      if (ch1_valid) begin
        if (n1 < 64) got1[n1] = ch1_data;
        n1++;
      end
      if ((ch0_valid && pv0) || (ch1_valid && pv1)) viol++;
      pv0 = ch0_valid;
      pv1 = ch1_valid;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_caps();
    n0 = 0; n1 = 0; got0 = '0; got1 = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset();
    settle(2);
    check("R1", "valid0 in reset", 64'(ch0_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valids after reset", {62'd0, ch1_valid, ch0_valid}, 64'd0);
    check("R1", "clk pin after reset", {62'd0, pdm_clk_oe, pdm_clk_out}, 64'd0);
  endtask

  // Slave clock with a half period of 2*SLV_STEP, unrelated to clk (R4).
  task automatic test_slave(input logic swap, input logic [1:0] en,
                            input logic [15:0] pa, input logic [15:0] pb, input string req);
    logic [15:0] e0, e1;
    int c0, c1;
    cfg_clk_master = 1'b0; cfg_edge_swap = swap; cfg_ch_en = en;
    settle(4);
    clear_caps();
    for (int k = 0; k < NB; k++) begin
      pdm_data = pa[k];   #(SLV_STEP);
      pdm_clk_in = 1'b1;  #(SLV_STEP);
      pdm_data = pb[k];   #(SLV_STEP);
      pdm_clk_in = 1'b0;  #(SLV_STEP);
    end
    settle(8);
    e0 = swap ? pb : pa;
    e1 = swap ? pa : pb;
    c0 = en[0] ? NB : 0;
    c1 = en[1] ? NB : 0;
    check(req, "oe in slave", 64'(pdm_clk_oe), 64'd0);
    check(req, "ch0 count R11", 64'(n0), 64'(c0));
    check(req, "ch1 count R11", 64'(n1), 64'(c1));
    if (en[0]) check(req, "ch0 bits R4", got0, 64'(e0));
    if (en[1]) check(req, "ch1 bits R4", got1, 64'(e1));
  endtask

  task automatic test_master(input logic rate, input logic swap,
                             input logic [15:0] pa, input logic [15:0] pb, input string req);
    cfg_clk_master = 1'b1; cfg_rate_fast = rate; cfg_edge_swap = swap; cfg_ch_en = 2'b11;
    pdm_data = pa[0];
    settle(4);
    clear_caps();
    cfg_clk_run = 1'b1;
    for (int k = 0; k < NB; k++) begin
      @(posedge pdm_clk_out);
      @(posedge clk); @(negedge clk);
      pdm_data = pb[k];
      @(negedge pdm_clk_out);
      @(posedge clk); @(negedge clk);
      if (k < NB-1) pdm_data = pa[k+1];
      else cfg_clk_run = 1'b0;
    end
    settle(10);
    check(req, "oe in master", 64'(pdm_clk_oe), 64'd1);
    check(req, "ch0 count", 64'(n0), 64'(NB));
    check(req, "ch1 count", 64'(n1), 64'(NB));
    check(req, "ch0 bits", got0, 64'(swap ? pb : pa));
    check(req, "ch1 bits", got1, 64'(swap ? pa : pb));
    cfg_clk_master = 1'b0;
    settle(4);
  endtask

  task automatic test_phases(input logic rate, input int exp, input string req);
    int hi, lo;
    cfg_clk_master = 1'b1; cfg_rate_fast = rate;
    settle(2);
    cfg_clk_run = 1'b1;
    @(posedge pdm_clk_out);
    hi = 0; lo = 0;
    @(negedge clk);
    while (pdm_clk_out) begin hi++; @(negedge clk); end
    while (!pdm_clk_out) begin lo++; @(negedge clk); end
    check(req, "high phase", 64'(hi), 64'(exp));
    check(req, "low phase", 64'(lo), 64'(exp));
    check(req, "oe", 64'(pdm_clk_oe), 64'd1);
    cfg_clk_run = 1'b0;
    settle(12);
  endtask

  task automatic test_gate();
    int hi, hits;
    cfg_clk_master = 1'b1; cfg_rate_fast = 1'b0; cfg_ch_en = 2'b11;
    settle(2);
    cfg_clk_run = 1'b1;
    @(posedge pdm_clk_out);
    @(negedge clk);
    hi = 1;
    cfg_clk_run = 1'b0;
    @(negedge clk);
    while (pdm_clk_out) begin hi++; @(negedge clk); end
    check("R9", "last high phase", 64'(hi), 64'd4);
    settle(6);
    clear_caps();
    hits = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pdm_clk_out) hits++;
    end
    check("R8", "gated clock highs", 64'(hits), 64'd0);
    check("R8", "gated strobes", 64'(n0 + n1), 64'd0);
    check("R8", "oe while gated", 64'(pdm_clk_oe), 64'd1);
    cfg_clk_master = 1'b0;
    settle(4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_slave(1'b0, 2'b11, 16'hB4E1, 16'h3C5A, "R2");
    test_slave(1'b1, 2'b11, 16'h96F0, 16'h0F69, "R3");
    test_slave(1'b0, 2'b01, 16'hA5C3, 16'h5A3C, "R10");
    test_slave(1'b0, 2'b10, 16'hC3A5, 16'h7E18, "R10");
    test_phases(1'b0, 4, "R5");
    test_phases(1'b1, 2, "R6");
    test_master(1'b0, 1'b0, 16'hD2B4, 16'h4B2D, "R7");
    test_master(1'b1, 1'b1, 16'h6E91, 16'h1F8C, "R7");
    test_gate();
    check("R11", "multi-cycle strobes", 64'(viol), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule